// File: doc/BRIEF.md
# Encrypted Configuration Security Controller

This block is the policy engine that stands between a configuration loader, a bitstream decryptor, the configuration memory and the key store. It remembers whether the design now resident was brought in encrypted. On that basis it grants or refuses readback and partial-load requests and decides whether a fresh load may replace the current one. An encrypted load always runs in a fixed order. The memory is first wiped. The bitstream is then loaded, and the decrypted result must pass an integrity test before the device counts as configured. Removing that design wipes the memory again.

Any attempt to reach the key store counts as tampering. It wins over every other request in the same cycle, pulses a key-erase strobe and forces a full memory clear. Once a design is live, the decryptor is locked away from user logic. The memory clear is a request/acknowledge pair: the clear request stays high until the memory answers with a done acknowledge. All outputs are registered, and the reset is synchronous and active high.

Top module: `cfg_guard`

## Requirements
- R1: After reset every output is 0, the controller is idle and the integrity error flag is clear.
- R2: A load request with `load_enc`=0 in the idle state raises `load_start` for exactly one cycle without raising `mem_clr_req`. A following `load_done` sets `cfg_valid` and `dec_lock` and leaves `enc_mode` at 0.
- R3: Readback (`rb_req`) and partial load (`pr_req`) get a one-cycle grant on their own port only while an unencrypted configuration is live. In any other state they get a one-cycle deny on their own port.
- R4: A load request with `load_enc`=1 sets `enc_mode` and holds `mem_clr_req` high until `mem_clr_ack`. Only after that acknowledge does `load_start` pulse.
- R5: After an encrypted `load_done`, the device is not configured until `chk_done` arrives with `chk_ok`=1. Then `cfg_valid`, `dec_lock` and `enc_mode` are all 1.
- R6: While an encrypted configuration is live, readback, partial and load requests each return a deny pulse and `cfg_valid` stays 1.
- R7: A load request over a live unencrypted configuration (a warm reload) is accepted. `cfg_valid` drops and `load_start` pulses.
- R8: Unloading an encrypted configuration holds `mem_clr_req` high until `mem_clr_ack` and then returns to idle with `enc_mode` 0. Unloading an unencrypted one returns to idle with no clear.
- R9: An integrity failure (`chk_done` with `chk_ok`=0) starts a memory clear and never sets `cfg_valid`. It sets `integ_err`, which stays 1 through later loads and tamper events until reset.
- R10: `tamper` in any state pulses `key_erase` one cycle later and drops `cfg_valid`. It raises `mem_clr_req` until a `mem_clr_ack` that arrives in a cycle without tamper, and it denies any request made in the same cycle.
- R11: `dec_lock` is 1 exactly while a configuration is live.
- R12: A load request while a clear, load, check or zeroize is under way returns a `load_deny` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Request to load a new configuration |
| load_enc | input | 1 | With load_req: bitstream is encrypted |
| load_done | input | 1 | Loader finished writing the bitstream |
| chk_done | input | 1 | Integrity result valid |
| chk_ok | input | 1 | With chk_done: integrity passed |
| unload_req | input | 1 | Remove the live configuration |
| rb_req | input | 1 | Configuration readback request |
| pr_req | input | 1 | Partial load request |
| tamper | input | 1 | Key-store access attempt |
| mem_clr_ack | input | 1 | Memory clear completed |
| rb_grant | output | 1 | Readback granted (pulse) |
| rb_deny | output | 1 | Readback refused (pulse) |
| pr_grant | output | 1 | Partial load granted (pulse) |
| pr_deny | output | 1 | Partial load refused (pulse) |
| load_deny | output | 1 | Load refused (pulse) |
| load_start | output | 1 | Start the loader (pulse) |
| mem_clr_req | output | 1 | Clear configuration memory, held until ack |
| key_erase | output | 1 | Erase key storage (pulse) |
| dec_lock | output | 1 | Decryptor withheld from user logic |
| cfg_valid | output | 1 | A configuration is live |
| enc_mode | output | 1 | Current or pending configuration is encrypted |
| integ_err | output | 1 | Sticky integrity failure flag |

## Verification
The case of most interest is tamper landing in the same cycle as another event. The bench drives `tamper` together with a readback request over a live design. It also drives `tamper` together with the `mem_clr_ack` that would otherwise end a zeroize, and together with `load_done` in the middle of a load. The bench judges each case by looking for a deny on the readback port and a key-erase pulse. It also checks that `mem_clr_req` stays high until a later, tamper-free acknowledge.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CLR_PRE  = 3'd1,
    ST_LOAD     = 3'd2,
    ST_CHECK    = 3'd3,
    ST_CONFIG   = 3'd4,
    ST_CLR_POST = 3'd5,
    ST_ZERO     = 3'd6
  } gstate_e;

  localparam int ACC_N  = 2;
  localparam int ACC_RB = 0;
  localparam int ACC_PR = 1;
endpackage

// File: rtl/cfg_guard_gate.sv
module cfg_guard_gate
  import cfg_guard_pkg::*;
#(
  parameter int N = ACC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  gstate_e      state,
  input  logic         enc_q,
  input  logic         tamper,
  input  logic [N-1:0] acc_req,
  input  logic         load_req,
  output logic [N-1:0] acc_grant,
  output logic [N-1:0] acc_deny,
  output logic         load_ok,
  output logic         load_deny
);
  logic acc_open;
  logic busy;

  // Access ports open only over a live plain-text design, and never under tamper.
  assign acc_open = (state == ST_CONFIG) && !enc_q && !tamper;
  assign load_ok  = !tamper && ((state == ST_IDLE) || ((state == ST_CONFIG) && !enc_q));
  assign busy     = (state == ST_CLR_PRE) || (state == ST_LOAD) || (state == ST_CHECK) ||
                    (state == ST_CLR_POST) || (state == ST_ZERO);

  generate
    for (genvar i = 0; i < N; i++) begin : g_acc
      always_ff @(posedge clk) begin
        if (rst) begin
          acc_grant[i] <= 1'b0;
          acc_deny[i]  <= 1'b0;
        end else begin
          acc_grant[i] <= acc_req[i] && acc_open;
          acc_deny[i]  <= acc_req[i] && !acc_open;
        end
      end

      // R3: a grant only follows a cycle with a live unencrypted design
      a_r3_grant_open: assert property (@(posedge clk) disable iff (rst)
        acc_grant[i] |-> $past((state == ST_CONFIG) && !enc_q));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) load_deny <= 1'b0;
    else     load_deny <= load_req && !load_ok;
  end

  a_r12_busy_deny: assert property (@(posedge clk) disable iff (rst)
    (load_req && busy) |=> load_deny);
endmodule

// File: rtl/cfg_guard_fsm.sv
module cfg_guard_fsm
  import cfg_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load_req,
  input  logic    load_enc,
  input  logic    load_ok,
  input  logic    load_done,
  input  logic    chk_done,
  input  logic    chk_ok,
  input  logic    unload_req,
  input  logic    tamper,
  input  logic    mem_clr_ack,
  output gstate_e state,
  output logic    enc_q,
  output logic    load_start,
  output logic    mem_clr_req,
  output logic    key_erase,
  output logic    dec_lock,
  output logic    cfg_valid,
  output logic    integ_err
);
  gstate_e nxt;
  logic    enc_n;
  logic    err_set;
  logic    take_load;

  assign take_load = load_req && load_ok;

  always_comb begin
    nxt     = state;
    enc_n   = enc_q;
    err_set = 1'b0;
    if (tamper) begin
      nxt = ST_ZERO;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_load) begin
            nxt   = load_enc ? ST_CLR_PRE : ST_LOAD;
            enc_n = load_enc;
          end
        end
        ST_CLR_PRE:  if (mem_clr_ack) nxt = ST_LOAD;
        ST_LOAD:     if (load_done) nxt = enc_q ? ST_CHECK : ST_CONFIG;
        ST_CHECK: begin
          if (chk_done) begin
            if (chk_ok) begin
              nxt = ST_CONFIG;
            end else begin
              nxt     = ST_CLR_POST;
              err_set = 1'b1;
            end
          end
        end
        ST_CONFIG: begin
          if (take_load) begin
            nxt   = load_enc ? ST_CLR_PRE : ST_LOAD;
            enc_n = load_enc;
          end else if (unload_req) begin
            nxt = enc_q ? ST_CLR_POST : ST_IDLE;
          end
        end
        ST_CLR_POST: if (mem_clr_ack) nxt = ST_IDLE;
        ST_ZERO:     if (mem_clr_ack) nxt = ST_IDLE;
        default:     nxt = ST_IDLE;
      endcase
    end
    if ((nxt == ST_IDLE) || (nxt == ST_ZERO)) enc_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      enc_q       <= 1'b0;
      load_start  <= 1'b0;
      mem_clr_req <= 1'b0;
      key_erase   <= 1'b0;
      dec_lock    <= 1'b0;
      cfg_valid   <= 1'b0;
      integ_err   <= 1'b0;
    end else begin
      state       <= nxt;
      enc_q       <= enc_n;
      load_start  <= (nxt == ST_LOAD) && (state != ST_LOAD);
      mem_clr_req <= (nxt == ST_CLR_PRE) || (nxt == ST_CLR_POST) || (nxt == ST_ZERO);
      key_erase   <= tamper;
      dec_lock    <= (nxt == ST_CONFIG);
      cfg_valid   <= (nxt == ST_CONFIG);
      integ_err   <= integ_err || err_set;
    end
  end

  // R10: tamper always erases keys and clears memory on the next cycle
  a_r10_tamper_wipe: assert property (@(posedge clk) disable iff (rst)
    tamper |=> (key_erase && mem_clr_req && !cfg_valid));

  // R4: an encrypted load only starts right after a memory clear
  a_r4_clear_first: assert property (@(posedge clk) disable iff (rst)
    (load_start && enc_q) |-> $past(mem_clr_req));

  // R9: integrity error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    integ_err |=> integ_err);

  // R6: a live encrypted design is not displaced by a refused request
  a_r6_enc_hold: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CONFIG) && enc_q && !tamper && !unload_req) |=> (state == ST_CONFIG));

  // R8: removal of an encrypted design clears memory
  a_r8_clear_after: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CONFIG) && enc_q && unload_req && !tamper) |=> mem_clr_req);
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_req,
  input  logic load_enc,
  input  logic load_done,
  input  logic chk_done,
  input  logic chk_ok,
  input  logic unload_req,
  input  logic rb_req,
  input  logic pr_req,
  input  logic tamper,
  input  logic mem_clr_ack,
  output logic rb_grant,
  output logic rb_deny,
  output logic pr_grant,
  output logic pr_deny,
  output logic load_deny,
  output logic load_start,
  output logic mem_clr_req,
  output logic key_erase,
  output logic dec_lock,
  output logic cfg_valid,
  output logic enc_mode,
  output logic integ_err
);
  gstate_e          state;
  logic             enc_q;
  logic             load_ok;
  logic [ACC_N-1:0] acc_req;
  logic [ACC_N-1:0] acc_grant;
  logic [ACC_N-1:0] acc_deny;

  assign acc_req[ACC_RB] = rb_req;
  assign acc_req[ACC_PR] = pr_req;
  assign rb_grant = acc_grant[ACC_RB];
  assign rb_deny  = acc_deny[ACC_RB];
  assign pr_grant = acc_grant[ACC_PR];
  assign pr_deny  = acc_deny[ACC_PR];
  assign enc_mode = enc_q;

  cfg_guard_gate #(.N(ACC_N)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .enc_q     (enc_q),
    .tamper    (tamper),
    .acc_req   (acc_req),
    .load_req  (load_req),
    .acc_grant (acc_grant),
    .acc_deny  (acc_deny),
    .load_ok   (load_ok),
    .load_deny (load_deny)
  );

  cfg_guard_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .load_req    (load_req),
    .load_enc    (load_enc),
    .load_ok     (load_ok),
    .load_done   (load_done),
    .chk_done    (chk_done),
    .chk_ok      (chk_ok),
    .unload_req  (unload_req),
    .tamper      (tamper),
    .mem_clr_ack (mem_clr_ack),
    .state       (state),
    .enc_q       (enc_q),
    .load_start  (load_start),
    .mem_clr_req (mem_clr_req),
    .key_erase   (key_erase),
    .dec_lock    (dec_lock),
    .cfg_valid   (cfg_valid),
    .integ_err   (integ_err)
  );
endmodule

// File: tb/tb_cfg_guard.sv
module tb_cfg_guard;
  localparam int CLK_PERIOD = 10;

  localparam logic [11:0] M_RBG = 12'h800;
  localparam logic [11:0] M_RBD = 12'h400;
  localparam logic [11:0] M_PRG = 12'h200;
  localparam logic [11:0] M_PRD = 12'h100;
  localparam logic [11:0] M_LDN = 12'h080;
  localparam logic [11:0] M_LST = 12'h040;
  localparam logic [11:0] M_CLR = 12'h020;
  localparam logic [11:0] M_KEY = 12'h010;
  localparam logic [11:0] M_LCK = 12'h008;
  localparam logic [11:0] M_CFG = 12'h004;
  localparam logic [11:0] M_ENC = 12'h002;
  localparam logic [11:0] M_ERR = 12'h001;
  localparam logic [11:0] M_ALL = 12'hFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_req = 0, load_enc = 0, load_done = 0, chk_done = 0, chk_ok = 0;
  logic unload_req = 0, rb_req = 0, pr_req = 0, tamper = 0, mem_clr_ack = 0;
  logic rb_grant, rb_deny, pr_grant, pr_deny, load_deny, load_start;
  logic mem_clr_req, key_erase, dec_lock, cfg_valid, enc_mode, integ_err;
  logic [11:0] obs;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int          at;
    logic [11:0] mask;
    logic [11:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  cfg_guard dut (
    .clk(clk), .rst(rst), .load_req(load_req), .load_enc(load_enc),
    .load_done(load_done), .chk_done(chk_done), .chk_ok(chk_ok),
    .unload_req(unload_req), .rb_req(rb_req), .pr_req(pr_req),
    .tamper(tamper), .mem_clr_ack(mem_clr_ack),
    .rb_grant(rb_grant), .rb_deny(rb_deny), .pr_grant(pr_grant), .pr_deny(pr_deny),
    .load_deny(load_deny), .load_start(load_start), .mem_clr_req(mem_clr_req),
    .key_erase(key_erase), .dec_lock(dec_lock), .cfg_valid(cfg_valid),
    .enc_mode(enc_mode), .integ_err(integ_err)
  );

  assign obs = {rb_grant, rb_deny, pr_grant, pr_deny, load_deny, load_start,
                mem_clr_req, key_erase, dec_lock, cfg_valid, enc_mode, integ_err};

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare queued expectations due in this cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if ((obs & e.mask) !== (e.val & e.mask)) begin
        n_bad++;
        $display("FAIL %s: cycle %0d outputs actual=%03h expected=%03h (mask %03h)",
                 e.tag, cyc, obs & e.mask, e.val & e.mask, e.mask);
      end
    end
  end

  // Driver side: expectation for the edge that captures the inputs set now.
  task automatic expect_out(input logic [11:0] m, input logic [11:0] v, input string tag);
    exp_t e;
    e.at = cyc + 1; e.mask = m; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
    load_req = 0; load_enc = 0; load_done = 0; chk_done = 0; chk_ok = 0;
    unload_req = 0; rb_req = 0; pr_req = 0; tamper = 0; mem_clr_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    tick(); expect_out(M_ALL, 12'h000, "R1");
    // R3: readback refused while idle
    tick(); rb_req = 1; expect_out(M_RBG | M_RBD, M_RBD, "R3");
    // R2: plain load
    tick(); load_req = 1; expect_out(M_LST | M_CLR | M_CFG, M_LST, "R2");
    tick(); expect_out(M_LST, 12'h000, "R2");
    tick(); load_done = 1; expect_out(M_CFG | M_LCK | M_ENC, M_CFG | M_LCK, "R2");
    tick(); expect_out(M_LCK, M_LCK, "R11");
    // R3: grants over a plain design
    tick(); rb_req = 1; expect_out(M_RBG | M_RBD, M_RBG, "R3");
    tick(); pr_req = 1; expect_out(M_PRG | M_PRD, M_PRG, "R3");
    // R7: warm reload
    tick(); load_req = 1; expect_out(M_LST | M_LDN | M_CFG | M_LCK, M_LST, "R7");
    tick(); load_done = 1; expect_out(M_CFG, M_CFG, "R7");
    // R8: plain unload, no clear
    tick(); unload_req = 1; expect_out(M_CFG | M_CLR | M_LCK, 12'h000, "R8");
    // R4: encrypted load clears first
    tick(); load_req = 1; load_enc = 1; expect_out(M_CLR | M_LST | M_ENC, M_CLR | M_ENC, "R4");
    tick(); load_req = 1; expect_out(M_LDN | M_CLR, M_LDN | M_CLR, "R12");
    tick(); mem_clr_ack = 1; expect_out(M_CLR | M_LST, M_LST, "R4");
    // R5: wait for integrity check
    tick(); load_done = 1; expect_out(M_CFG | M_LCK, 12'h000, "R5");
    tick(); pr_req = 1; expect_out(M_PRG | M_PRD, M_PRD, "R3");
    tick(); chk_done = 1; chk_ok = 1;
    expect_out(M_CFG | M_LCK | M_ENC | M_ERR, M_CFG | M_LCK | M_ENC, "R5");
    // R6: restrictions over encrypted design
    tick(); rb_req = 1; expect_out(M_RBG | M_RBD | M_CFG, M_RBD | M_CFG, "R6");
    tick(); pr_req = 1; expect_out(M_PRG | M_PRD | M_CFG, M_PRD | M_CFG, "R6");
    tick(); load_req = 1; expect_out(M_LDN | M_LST | M_CFG | M_CLR, M_LDN | M_CFG, "R6");
    // R8: encrypted unload clears after
    tick(); unload_req = 1; expect_out(M_CLR | M_CFG | M_LCK | M_ENC, M_CLR | M_ENC, "R8");
    tick(); expect_out(M_CLR, M_CLR, "R8");
    tick(); mem_clr_ack = 1; expect_out(M_CLR | M_ENC, 12'h000, "R8");
    // R9: integrity failure
    tick(); load_req = 1; load_enc = 1;
    tick(); mem_clr_ack = 1;
    tick(); load_done = 1;
    tick(); chk_done = 1; chk_ok = 0;
    expect_out(M_CLR | M_CFG | M_ERR | M_LCK, M_CLR | M_ERR, "R9");
    tick(); mem_clr_ack = 1; expect_out(M_CLR | M_ERR | M_CFG, M_ERR, "R9");
    // R10: tamper with a readback in the same cycle
    tick(); load_req = 1;
    tick(); load_done = 1; expect_out(M_CFG, M_CFG, "R2");
    tick(); tamper = 1; rb_req = 1;
    expect_out(M_KEY | M_CLR | M_CFG | M_RBG | M_RBD | M_LCK | M_ENC, M_KEY | M_CLR | M_RBD, "R10");
    tick(); tamper = 1; mem_clr_ack = 1; expect_out(M_KEY | M_CLR, M_KEY | M_CLR, "R10");
    tick(); expect_out(M_KEY | M_CLR, M_CLR, "R10");
    tick(); mem_clr_ack = 1; expect_out(M_CLR | M_ERR, M_ERR, "R9");
    // R10: tamper beats load_done
    tick(); load_req = 1;
    tick(); tamper = 1; load_done = 1; expect_out(M_KEY | M_CLR | M_CFG, M_KEY | M_CLR, "R10");
    tick(); mem_clr_ack = 1; expect_out(M_CLR, 12'h000, "R10");
    // R1: reset clears the sticky flag
    tick(); rst = 1;
    tick(); rst = 0; expect_out(M_ALL, 12'h000, "R1");
    repeat (3) tick();
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: pending checks actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule